// File: doc/BRIEF.md
# Encoded UART Baud Divisor Generator

This block turns a crystal-derived reference clock into the timing strobes a UART needs. A 4-bit rate code picks one of sixteen divisors. Codes 0 to 7 give the powers of two from 1 to 128. Codes 8 to 15 give three times those powers, from 3 to 384. The block emits a one-cycle sample strobe once per divisor count of reference cycles, which is the 16x oversampling rate. It also emits a bit strobe on every sixteenth sample strobe, so the bit rate is the reference divided by sixteen times the divisor.

A static strap tells the block whether the reference is the 1.8432 MHz crystal or the 3.6864 MHz one. With the low reference the code maps straight onto the divisor table, so code 0 gives 115200 baud, code 1 gives 57600, code 8 gives 38400, code 10 gives 9600 and code 15 gives 300. With the high reference the block keeps the meaning of the code as a baud rate and uses the divisor of the next code up (twice as large). There are three exceptions. Code 0 still picks divisor 1, which is the 230400 baud maximum. Codes 7 and 15 have no larger entry in their group, so they stay at 128 and 384; 300 baud therefore cannot be reached, and code 15 gives 600.

A one-cycle load pulse captures the code and the strap and restarts both counters at once. No strobe appears in the cycle that follows the load edge.

Top module: `baud_tick_gen`

## Requirements
- R1: With the strap low, codes 0..7 (bit 3 clear) give a sample strobe period of 2^code reference cycles.
- R2: With the strap low, codes 8..15 (bit 3 set) give a period of 3 * 2^(code-8) reference cycles.
- R3: The sample strobe is high for exactly one cycle per period. After the load edge (edge 0), it is high after edges P, 2P, 3P and so on, where P is the active divisor.
- R4: The bit strobe is high only together with a sample strobe, and only on every 16th sample strobe after a load or reset, which is after edge 16*P.
- R5: With the strap high, code 0 selects divisor 1.
- R6: With the strap high, any code other than 0, 7 and 15 selects the divisor that the strap-low table gives for code+1.
- R7: With the strap high, codes 7 and 15 select divisors 128 and 384, the largest entries of their groups.
- R8: A load clears the prescaler and the bit counter. Both strobes are low after the load edge, even if the old count was about to wrap.
- R9: After reset the active code is 0 with the strap low (divisor 1). The sample strobe is high after every edge, and the bit strobe is high after the 16th edge.
- R10: Changes on the code or strap inputs have no effect while load is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock from the crystal |
| rst_ni | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | One-cycle pulse that captures code and strap and restarts the counters |
| rate_code_i | input | 4 | Divisor code (bit 3 selects the three-times group, bits 2:0 the power) |
| ref_high_i | input | 1 | Strap: 1 means the 3.6864 MHz reference, 0 means the 1.8432 MHz reference |
| sample_tick_o | output | 1 | One-cycle 16x oversampling strobe |
| bit_tick_o | output | 1 | One-cycle strobe on every 16th sample strobe |

## Verification
The assertions assume that load is a clean synchronous input, sampled only at clock edges, and that the strap is stable from one load to the next. The checks on strobe spacing only reason from the counter state that the most recent load left behind. The stimulus drives every input at the falling edge and pulses load for a single cycle. For all 32 combinations of code and strap, it runs a full sixteen-sample window before the next load, so every window the assertions watch starts from a clean restart. It also drops a load exactly where a wrap was due, and it moves the inputs without any load at all.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int unsigned CODE_W  = 4;
    localparam int unsigned POW_W   = CODE_W - 1;
    localparam int unsigned MAX_POW = (1 << POW_W) - 1;
    localparam int unsigned MAX_DIV = 3 << MAX_POW;
    localparam int unsigned DIV_W   = $clog2(MAX_DIV + 1);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              high;
    } rate_cfg_t;
endpackage

// File: rtl/baud_code_decode.sv
module baud_code_decode
    import baud_pkg::*;
(
    input  rate_cfg_t        cfg_i,
    output logic [DIV_W-1:0] last_o
);
    logic [POW_W-1:0] pow;
    logic [DIV_W-1:0] base;
    logic [DIV_W-1:0] div;

    always_comb begin
        pow = cfg_i.code[POW_W-1:0];
        if (cfg_i.high && (cfg_i.code != '0) && (pow != POW_W'(MAX_POW))) begin
            pow = pow + POW_W'(1);
        end
        base   = cfg_i.code[CODE_W-1] ? DIV_W'(3) : DIV_W'(1);
        div    = base << pow;
        last_o = div - DIV_W'(1);
    end
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic [DIV_W-1:0] last_i,
    output logic             wrap_o,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = (st_q.cnt == last_i);
        if (clear_i) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b0;
        end else begin
            st_d.cnt  = wrap_o ? '0 : st_q.cnt + DIV_W'(1);
            st_d.tick = wrap_o;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    // R3
    cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= last_i);

    // R3
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.tick && (last_i != '0) && !clear_i) |=> !st_q.tick);
endmodule

// File: rtl/baud_bit_counter.sv
module baud_bit_counter #(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic wrap_i,
    output logic tick_o
);
    localparam int unsigned CNT_W = $clog2(OVERSAMPLE);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } bit_state_t;

    bit_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b0;
        end else begin
            st_d.tick = wrap_i && (st_q.cnt == LAST);
            if (wrap_i) begin
                st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    // R4
    bit_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.tick |-> (st_q.cnt == '0));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [CODE_W-1:0] rate_code_i,
    input  logic              ref_high_i,
    output logic              sample_tick_o,
    output logic              bit_tick_o
);
    rate_cfg_t        cfg_d, cfg_q;
    logic [DIV_W-1:0] last;
    logic             wrap;

    always_comb begin
        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d.code = rate_code_i;
            cfg_d.high = ref_high_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    baud_code_decode u_dec (
        .cfg_i  (cfg_q),
        .last_o (last)
    );

    baud_prescaler u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (load_i),
        .last_i  (last),
        .wrap_o  (wrap),
        .tick_o  (sample_tick_o)
    );

    baud_bit_counter #(.OVERSAMPLE(OVERSAMPLE)) u_bit (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (load_i),
        .wrap_i  (wrap),
        .tick_o  (bit_tick_o)
    );

    // R4
    bit_with_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_tick_o |-> sample_tick_o);

    // R8
    load_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (!sample_tick_o && !bit_tick_o));

    // R10
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(cfg_q));
endmodule

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic [3:0] code = 4'd0;
    logic       high = 1'b0;
    logic       stick, btick;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    baud_tick_gen u0 (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .load_i        (load),
        .rate_code_i   (code),
        .ref_high_i    (high),
        .sample_tick_o (stick),
        .bit_tick_o    (btick)
    );

    function automatic int exp_div(input logic [3:0] c, input logic h);
        int p = c[2:0];
        int b = c[3] ? 3 : 1;
        if (h && c != 4'd0 && p != 7) p = p + 1;
        return b * (1 << p);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [3:0] c, input logic h);
        load = 1'b1; code = c; high = h;
        @(negedge clk);
        load = 1'b0;
    endtask

    // sweep one window of 16 sample periods after a load
    task automatic run_window(input logic [3:0] c, input logic h, input string tag);
        int p = exp_div(c, h);
        int s_err = 0, b_err = 0, s_act = 0, b_act = 0, s_exp = 0, b_exp = 0;
        do_load(c, h);
        for (int n = 1; n <= 16 * p; n++) begin
            @(negedge clk);
            if (stick !== ((n % p) == 0) && s_err == 0) begin
                s_err = n; s_act = stick; s_exp = ((n % p) == 0);
            end
            if (btick !== (n == 16 * p) && b_err == 0) begin
                b_err = n; b_act = btick; b_exp = (n == 16 * p);
            end
        end
        check(s_err == 0, $sformatf("%s sample code=%0d high=%0d edge=%0d", tag, c, h, s_err), s_act, s_exp);
        check(b_err == 0, $sformatf("R4 bit code=%0d high=%0d edge=%0d", c, h, b_err), b_act, b_exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(stick === 1'b0 && btick === 1'b0, "R9 reset low", stick, 0);
        rst_n = 1'b1;
        // R9: divisor 1 after reset
        for (int n = 1; n <= 16; n++) begin
            @(negedge clk);
            check(stick === 1'b1, $sformatf("R9 sample edge %0d", n), stick, 1);
            check(btick === (n == 16), $sformatf("R9 bit edge %0d", n), btick, (n == 16));
        end

        // R1, R2, R5, R6, R7 sweeps
        for (int c = 0; c < 16; c++)
            run_window(4'(c), 1'b0, (c < 8) ? "R1" : "R2");
        for (int c = 0; c < 16; c++)
            run_window(4'(c), 1'b1, (c == 0) ? "R5" : ((c == 7 || c == 15) ? "R7" : "R6"));

        // R3: one pulse per period, several periods, divisor 6
        do_load(4'd9, 1'b0);
        for (int n = 1; n <= 24; n++) begin
            @(negedge clk);
            check(stick === ((n % 6) == 0), $sformatf("R3 edge %0d", n), stick, ((n % 6) == 0));
        end

        // R8: load right where the old count would wrap
        do_load(4'd2, 1'b0);
        repeat (3) @(negedge clk);
        load = 1'b1; code = 4'd1; high = 1'b0;
        @(negedge clk);
        load = 1'b0;
        check(stick === 1'b0 && btick === 1'b0, "R8 no tick after load", stick, 0);
        @(negedge clk);
        check(stick === 1'b0, "R8 restart edge 1", stick, 0);
        @(negedge clk);
        check(stick === 1'b1, "R8 restart edge 2", stick, 1);

        // R10: inputs move without load, divisor 4 kept
        do_load(4'd2, 1'b0);
        code = 4'd0; high = 1'b1;
        for (int n = 1; n <= 12; n++) begin
            @(negedge clk);
            if (n == 5) begin code = 4'd15; high = 1'b0; end
            check(stick === ((n % 4) == 0), $sformatf("R10 edge %0d", n), stick, ((n % 4) == 0));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule